// File: doc/BRIEF.md
# Priority-Threshold Interrupt Controller

This block gathers sixteen numbered interrupt sources and one bypass interrupt into a single 6-bit vector output. Each source reports activity through single-cycle strobes. An assert strobe marks the source pending in an active-low status register. The assert strobe is passed on as a vector event only when the source's 3-bit priority is strictly above a software-set threshold. A release strobe on any input sends a vector of zero, which tells the consumer to drop the request.

Software uses a small 32-bit register bus with byte enables. The bus reaches the status register, the threshold register and four priority registers, and each priority register holds four sources. The bypass input skips masking and status entirely and always produces vector 32. A forwarded source produces vector 16 plus its index. The vector output is registered and carries a one-cycle valid strobe. It keeps its last value until the next event. Reset is synchronous.

Top module: `irq_prio_ctrl`

## Requirements
- R1: A synchronous reset sets status to 0x0000FFFF and sets threshold and all four priority registers to zero. It also clears `vec_valid` and `vec_out`.
- R2: `bus_addr[4:2]` selects the word: 0 is status, 1 is threshold, and 4 to 7 are the priority registers. The other words read as zero and ignore writes. `bus_rdata` follows `bus_addr` in the same cycle.
- R3: During a write (`bus_wr`=1), lane k of `bus_be` updates only bits 8k+7..8k of the addressed register.
- R4: An assert strobe on source s drives status bit s to 0 at the next edge. This takes precedence over a software write to that bit in the same cycle.
- R5: The priority of source s is bits 8*(s%4)+2..8*(s%4) of priority word 4+s/4.
- R6: A source is forwarded only when its priority is greater than the 32-bit threshold value, compared unsigned. When it is forwarded, the next cycle shows `vec_valid`=1 and `vec_out`=16+s. A priority equal to the threshold gives no event.
- R7: A bypass assert strobe gives `vec_valid`=1 and `vec_out`=32 in the next cycle, whatever the threshold. It does not touch status, and it wins over every source in the same cycle.
- R8: When several sources qualify in the same cycle, the lowest index is sent. The other sources only record their status bits.
- R9: A release strobe on any source or on the bypass input gives `vec_valid`=1 and `vec_out`=0 in the next cycle. This happens only when no assert is forwarded in the same cycle.
- R10: When no event is produced, `vec_valid` is 0 and `vec_out` keeps its previous value.
- R11: Writing 1 to a pending status bit returns it to the idle (1) state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Write request for the addressed word |
| bus_addr | input | 5 | Byte address within the 32-byte window |
| bus_be | input | 4 | Byte lane enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed word |
| src_on | input | 16 | Assert strobes, one per source |
| src_off | input | 16 | Release strobes, one per source |
| byp_on | input | 1 | Bypass assert strobe |
| byp_off | input | 1 | Bypass release strobe |
| vec_valid | output | 1 | One-cycle event strobe |
| vec_out | output | 6 | Vector number, held between events |

## Verification
The bench builds the block with its default parameters: sixteen sources, 3-bit priorities, 6-bit vectors, base vector 16 and bypass vector 32. With these values every priority from 0 to 7 can be compared against thresholds both below and above the maximum priority. This reaches the equal-priority boundary and the case where the threshold masks everything. Random threshold writes are mostly kept within 0 to 8, so that forwarding, masking and multi-source ties all occur often. The sparse random strobe patterns also make bypass, release and assert strobes coincide in the same cycle.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int WORD_W = 32;
  localparam int LANES  = WORD_W / 8;
  localparam int IDX_W  = 3;

  localparam logic [IDX_W-1:0] W_STAT     = 3'd0;
  localparam logic [IDX_W-1:0] W_THRESH   = 3'd1;
  localparam logic [IDX_W-1:0] W_PRIO_LO  = 3'd4;

  typedef enum logic [1:0] {EV_NONE, EV_BYPASS, EV_SOURCE, EV_RELEASE} ev_kind_e;

  function automatic logic [WORD_W-1:0] lane_merge(input logic [WORD_W-1:0] old_w,
                                                   input logic [WORD_W-1:0] new_w,
                                                   input logic [LANES-1:0] be);
    logic [WORD_W-1:0] r;
    r = old_w;
    for (int k = 0; k < LANES; k++)
      if (be[k]) r[8*k +: 8] = new_w[8*k +: 8];
    return r;
  endfunction
endpackage

// File: rtl/irqc_regfile.sv
module irqc_regfile
  import irqc_pkg::*;
#(
  parameter int NSRC  = 16,
  parameter int LVL_W = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [IDX_W-1:0]        word_idx,
  input  logic [LANES-1:0]        be,
  input  logic [WORD_W-1:0]       wdata,
  input  logic [NSRC-1:0]         pend_set,
  output logic [WORD_W-1:0]       rdata,
  output logic [WORD_W-1:0]       stat_q,
  output logic [WORD_W-1:0]       thresh_q,
  output logic [NSRC*LVL_W-1:0]   prio_flat
);
  localparam int PER_WORD = LANES;
  localparam int NPRIO    = (NSRC + PER_WORD - 1) / PER_WORD;
  localparam logic [WORD_W-1:0] STAT_RST = {{(WORD_W-NSRC){1'b0}}, {NSRC{1'b1}}};

  logic [WORD_W-1:0] prio_q [NPRIO];
  logic [WORD_W-1:0] stat_d;

  always_comb begin
    stat_d = stat_q;
    if (wr_en && word_idx == W_STAT) stat_d = lane_merge(stat_q, wdata, be);
    stat_d[NSRC-1:0] = stat_d[NSRC-1:0] & ~pend_set;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q   <= STAT_RST;
      thresh_q <= '0;
    end else begin
      stat_q <= stat_d;
      if (wr_en && word_idx == W_THRESH) thresh_q <= lane_merge(thresh_q, wdata, be);
    end
  end

  for (genvar i = 0; i < NPRIO; i++) begin : g_prio
    always_ff @(posedge clk) begin
      if (rst) prio_q[i] <= '0;
      else if (wr_en && word_idx == W_PRIO_LO + IDX_W'(i))
        prio_q[i] <= lane_merge(prio_q[i], wdata, be);
    end
  end

  for (genvar s = 0; s < NSRC; s++) begin : g_field
    assign prio_flat[s*LVL_W +: LVL_W] = prio_q[s / PER_WORD][8*(s % PER_WORD) +: LVL_W];
  end

  always_comb begin
    rdata = '0;
    if (word_idx == W_STAT)   rdata = stat_q;
    if (word_idx == W_THRESH) rdata = thresh_q;
    for (int i = 0; i < NPRIO; i++)
      if (word_idx == W_PRIO_LO + IDX_W'(i)) rdata = prio_q[i];
  end
endmodule

// File: rtl/irqc_vector_sel.sv
module irqc_vector_sel
  import irqc_pkg::*;
#(
  parameter int NSRC     = 16,
  parameter int LVL_W    = 3,
  parameter int VEC_W    = 6,
  parameter int VEC_BASE = 16,
  parameter int BYP_VEC  = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NSRC-1:0]       on_stb,
  input  logic                  any_off,
  input  logic                  byp_on,
  input  logic [NSRC*LVL_W-1:0] prio_flat,
  input  logic [WORD_W-1:0]     thresh,
  output logic                  vec_valid,
  output logic [VEC_W-1:0]      vec_out
);
  logic [NSRC-1:0] qual;
  logic [VEC_W-1:0] win_vec;
  logic [VEC_W-1:0] nxt_vec;
  ev_kind_e kind;

  for (genvar s = 0; s < NSRC; s++) begin : g_qual
    assign qual[s] = on_stb[s] && (WORD_W'(prio_flat[s*LVL_W +: LVL_W]) > thresh);
  end

  always_comb begin
    win_vec = '0;
    for (int s = NSRC - 1; s >= 0; s--)
      if (qual[s]) win_vec = VEC_W'(VEC_BASE + s);
  end

  always_comb begin
    if (byp_on)       kind = EV_BYPASS;
    else if (|qual)   kind = EV_SOURCE;
    else if (any_off) kind = EV_RELEASE;
    else              kind = EV_NONE;
    case (kind)
      EV_BYPASS: nxt_vec = VEC_W'(BYP_VEC);
      EV_SOURCE: nxt_vec = win_vec;
      default:   nxt_vec = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_valid <= 1'b0;
      vec_out   <= '0;
    end else begin
      vec_valid <= (kind != EV_NONE);
      if (kind != EV_NONE) vec_out <= nxt_vec;
    end
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irqc_pkg::*;
#(
  parameter int NSRC     = 16,
  parameter int LVL_W    = 3,
  parameter int VEC_W    = 6,
  parameter int VEC_BASE = 16,
  parameter int BYP_VEC  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [4:0]        bus_addr,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NSRC-1:0]   src_on,
  input  logic [NSRC-1:0]   src_off,
  input  logic              byp_on,
  input  logic              byp_off,
  output logic              vec_valid,
  output logic [VEC_W-1:0]  vec_out
);
  logic [WORD_W-1:0]     stat_q;
  logic [WORD_W-1:0]     thresh_q;
  logic [NSRC*LVL_W-1:0] prio_flat;

  irqc_regfile #(.NSRC(NSRC), .LVL_W(LVL_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(bus_wr), .word_idx(bus_addr[4:2]), .be(bus_be),
    .wdata(bus_wdata), .pend_set(src_on), .rdata(bus_rdata), .stat_q(stat_q),
    .thresh_q(thresh_q), .prio_flat(prio_flat)
  );

  irqc_vector_sel #(.NSRC(NSRC), .LVL_W(LVL_W), .VEC_W(VEC_W),
                    .VEC_BASE(VEC_BASE), .BYP_VEC(BYP_VEC)) u_sel (
    .clk(clk), .rst(rst), .on_stb(src_on), .any_off((|src_off) | byp_off),
    .byp_on(byp_on), .prio_flat(prio_flat), .thresh(thresh_q),
    .vec_valid(vec_valid), .vec_out(vec_out)
  );
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int NSRC     = 16,
  parameter int VEC_W    = 6,
  parameter int VEC_BASE = 16,
  parameter int BYP_VEC  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic [NSRC-1:0]   src_on,
  input logic [NSRC-1:0]   src_off,
  input logic              byp_on,
  input logic              byp_off,
  input logic              vec_valid,
  input logic [VEC_W-1:0]  vec_out,
  input logic [31:0]       stat_q,
  input logic [31:0]       thresh_q
);
  localparam logic [31:0] STAT_RST = {{(32-NSRC){1'b0}}, {NSRC{1'b1}}};

  a_r1_reset_vals: assert property (@(posedge clk)
    rst |=> (stat_q == STAT_RST && thresh_q == '0 && !vec_valid && vec_out == '0));

  a_r4_pending_low: assert property (@(posedge clk) disable iff (rst)
    (|src_on) |=> ((stat_q[NSRC-1:0] & $past(src_on)) == '0));

  a_r7_bypass_vec: assert property (@(posedge clk) disable iff (rst)
    byp_on |=> (vec_valid && vec_out == VEC_W'(BYP_VEC)));

  a_r7_bypass_no_status: assert property (@(posedge clk) disable iff (rst)
    (byp_on && src_on == '0 && !bus_wr) |=> $stable(stat_q));

  a_r9_release_zero: assert property (@(posedge clk) disable iff (rst)
    (!byp_on && src_on == '0 && ((|src_off) || byp_off)) |=> (vec_valid && vec_out == '0));

  a_r10_quiet_hold: assert property (@(posedge clk) disable iff (rst)
    (src_on == '0 && src_off == '0 && !byp_on && !byp_off) |=> (!vec_valid && $stable(vec_out)));

  a_r6_vec_range: assert property (@(posedge clk) disable iff (rst)
    (vec_valid && vec_out != '0 && vec_out != VEC_W'(BYP_VEC)) |->
      (vec_out >= VEC_W'(VEC_BASE) && vec_out < VEC_W'(VEC_BASE + NSRC)));
endmodule

bind irq_prio_ctrl irqc_checker #(.NSRC(NSRC), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE),
                                  .BYP_VEC(BYP_VEC)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .src_on(src_on), .src_off(src_off),
  .byp_on(byp_on), .byp_off(byp_off), .vec_valid(vec_valid), .vec_out(vec_out),
  .stat_q(stat_q), .thresh_q(thresh_q)
);

// File: tb/test_irq_prio_ctrl.sv
`timescale 1ns/1ps
module test_irq_prio_ctrl;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst, bus_wr, byp_on, byp_off, vec_valid;
  logic [4:0] bus_addr;
  logic [3:0] bus_be;
  logic [31:0] bus_wdata, bus_rdata;
  logic [15:0] src_on, src_off;
  logic [5:0] vec_out;

  irq_prio_ctrl i_irq_prio_ctrl (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_on(src_on), .src_off(src_off),
    .byp_on(byp_on), .byp_off(byp_off), .vec_valid(vec_valid), .vec_out(vec_out)
  );

  int errs = 0, checks = 0;
  bit done = 0;
  logic [31:0] m_stat, m_mask;
  logic [31:0] m_lvl [4];
  logic [5:0]  m_vec;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] lvl_of(input int s);
    return m_lvl[s/4][8*(s%4) +: 3];
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] n, input logic [3:0] be);
    logic [31:0] r = o;
    for (int k = 0; k < 4; k++) if (be[k]) r[8*k +: 8] = n[8*k +: 8];
    return r;
  endfunction

  function automatic logic [31:0] m_read(input int idx);
    if (idx == 0) return m_stat;
    if (idx == 1) return m_mask;
    if (idx >= 4) return m_lvl[idx-4];
    return 32'h0;
  endfunction

  task automatic rd(input int idx, input string tag);
    bus_addr = 5'(idx * 4);
    #1;
    chk(bus_rdata === m_read(idx), tag, bus_rdata, m_read(idx));
  endtask

  task automatic step(input logic wr, input logic [4:0] addr, input logic [3:0] be,
                      input logic [31:0] wd, input logic [15:0] on, input logic [15:0] off,
                      input logic bon, input logic boff);
    bit ev = 0;
    logic [5:0] ev_vec = m_vec;
    string tag = "R10 quiet";
    int nq = 0;
    bus_wr = wr; bus_addr = addr; bus_be = be; bus_wdata = wd;
    src_on = on; src_off = off; byp_on = bon; byp_off = boff;
    for (int s = 15; s >= 0; s--)
      if (on[s] && 32'(lvl_of(s)) > m_mask) begin ev_vec = 6'(16 + s); nq++; end
    if (bon) begin ev = 1; ev_vec = 6'd32; tag = "R7 bypass"; end
    else if (nq > 0) begin ev = 1; tag = (nq > 1) ? "R8 lowest wins" : "R6 forward"; end
    else if ((|off) || boff) begin ev = 1; ev_vec = 6'd0; tag = "R9 release"; end
    else if (|on) tag = "R6 masked";
    @(posedge clk); #1;
    bus_wr = 0; src_on = '0; src_off = '0; byp_on = 0; byp_off = 0;
    chk(vec_valid === ev, tag, 32'(vec_valid), 32'(ev));
    chk(vec_out === ev_vec, tag, 32'(vec_out), 32'(ev_vec));
    if (wr) begin
      case (int'(addr[4:2]))
        0: m_stat = merge(m_stat, wd, be);
        1: m_mask = merge(m_mask, wd, be);
        4, 5, 6, 7: m_lvl[addr[4:2]-4] = merge(m_lvl[addr[4:2]-4], wd, be);
        default: ;
      endcase
    end
    m_stat[15:0] = m_stat[15:0] & ~on;
    m_vec = ev_vec;
    @(negedge clk);
  endtask

  task automatic idle_step(input logic [15:0] on, input logic [15:0] off, input logic bon, input logic boff);
    step(0, 5'd0, 4'd0, 32'd0, on, off, bon, boff);
  endtask

  task automatic wr_step(input logic [4:0] addr, input logic [3:0] be, input logic [31:0] wd);
    step(1, addr, be, wd, '0, '0, 0, 0);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1957));
    rst = 1; bus_wr = 0; bus_addr = '0; bus_be = '0; bus_wdata = '0;
    src_on = '0; src_off = '0; byp_on = 0; byp_off = 0;
    m_stat = 32'h0000FFFF; m_mask = 0; m_vec = 0;
    for (int i = 0; i < 4; i++) m_lvl[i] = 0;
    repeat (2) @(posedge clk);
    @(negedge clk); rst = 0;
    chk(vec_valid === 1'b0, "R1 valid after reset", 32'(vec_valid), 0);
    chk(vec_out === 6'd0, "R1 vec after reset", 32'(vec_out), 0);
    for (int i = 0; i < 8; i++) rd(i, "R1 reset value");

    wr_step(5'h10, 4'b0010, 32'hA5A5_0B77);   // R3: only lane 1 -> src1 field gets 3
    rd(4, "R3 single lane");
    wr_step(5'h14, 4'b0001, 32'hFFFF_FFFF);   // R5: src4 priority 7
    rd(5, "R5 field layout");
    wr_step(5'h04, 4'b1111, 32'd2);
    idle_step(16'h0002, '0, 0, 0);             // R6: 3 > 2 -> 17
    rd(0, "R4 pending bit low");
    wr_step(5'h04, 4'b0001, 32'd3);
    idle_step(16'h0002, '0, 0, 0);             // R6: equal priority masked
    wr_step(5'h00, 4'b0001, 32'h0000_0002);    // R11
    rd(0, "R11 write one releases");
    wr_step(5'h04, 4'b0001, 32'd7);
    idle_step(16'h0010, '0, 1, 0);             // R7 bypass wins over src4
    rd(0, "R7 source status still recorded");
    idle_step('0, '0, 1, 0);
    rd(0, "R7 bypass leaves status");
    wr_step(5'h04, 4'b1111, 32'd0);
    idle_step(16'h0013, '0, 0, 0);             // R8: src1 wins
    idle_step('0, 16'h8000, 0, 0);             // R9
    idle_step('0, '0, 0, 1);                   // R9 bypass release
    idle_step('0, '0, 0, 0);                   // R10
    wr_step(5'h08, 4'b1111, 32'hDEAD_BEEF);    // R2 unmapped
    rd(2, "R2 unmapped reads zero");
    rd(3, "R2 unmapped reads zero");
    step(1, 5'h00, 4'b0011, 32'h0000_FFFF, 16'h2000, '0, 0, 0); // R4 event beats write
    rd(0, "R4 event over write");

    for (int n = 0; n < 1500; n++) begin
      logic wr = ($urandom % 4) == 0;
      logic [4:0] a = {3'($urandom % 8), 2'b00};
      logic [31:0] wd = $urandom;
      if (a[4:2] == 3'd1 && ($urandom % 8) != 0) wd = $urandom % 9;
      step(wr, a, 4'($urandom), wd, 16'($urandom & $urandom & $urandom),
           16'($urandom & $urandom & $urandom & $urandom), ($urandom % 10) == 0,
           ($urandom % 16) == 0);
      if (n % 100 == 0)
        for (int i = 0; i < 8; i++) rd(i, "R2 R4 random readback");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule